// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a target FPGA over its slave-serial configuration pins. On a start request it switches on the target's supply, waits for the supply to settle, parks the programming pins in a known state, applies a timed active-low programming pulse and then clocks the configuration image into the target one bit at a time. Every wait is a parameter counted in fabric clock cycles, so one design serves any fabric clock rate.

Image bytes arrive on a ready/valid byte stream. The byte count and a word-swap mode flag are captured when the start is accepted. In word-swap mode the block collects each group of four bytes and sends them last-first. This lets an image that was stored as little-endian 32-bit words go out in the order the target expects. The mode is only allowed for an image that starts on a 32-bit boundary. The requester reports that alignment on a flag, and an unaligned word-swap request runs the power and programming pulse but sends no data. A busy level covers the whole run, and a one-cycle done pulse marks its end.

Top module: `fcfg_seq`

## Requirements
- R1: After reset, and before any start: pwr_en=0, prog_n=1, cclk=0, din=0, busy=0, done=0, in_ready=0.
- R2: A start that is sampled while busy=0 is accepted. From the next cycle pwr_en is 1, and it stays 1 until reset. For the first T_PWR+T_SETUP cycles after acceptance, prog_n stays 1 and cclk stays 0.
- R3: prog_n is 0 for exactly T_PROG cycles, starting T_PWR+T_SETUP cycles after acceptance. cclk stays 0 until that pulse has ended.
- R4: Each byte goes out most significant bit first. din takes a bit's value before cclk rises and holds it while cclk is high. The target takes the bit on the rising edge of cclk.
- R5: Each cclk high phase lasts exactly CCLK_HALF cycles. Between two rising edges, cclk is low for at least CCLK_HALF cycles.
- R6: With swap=0, exactly byte_count bytes are sent, in the order they arrive.
- R7: With swap=1 and aligned=1, output byte k is input byte k XOR 3. This gives the order 3,2,1,0,7,6,5,4. Four input bytes are buffered before a group is sent, and in_ready is 0 while a group is being sent.
- R8: With swap=1 and aligned=1, the two low bits of byte_count are ignored, so only whole 4-byte groups are taken and sent.
- R9: With swap=1 and aligned=0, no byte is accepted and cclk never rises. The power wait and the programming pulse still run, and done is still given.
- R10: in_ready is 1 only after the programming pulse has ended. It is 0 once the run's byte total has been accepted, so no byte beyond that total is taken.
- R11: busy is 1 from the cycle after acceptance through the done cycle. done is a one-cycle pulse given after the last cclk fall. busy is 0 in the cycle after done.
- R12: A start while busy=1 is ignored: no second power or programming sequence follows, and the bit stream is unchanged.
- R13: A run with a byte total of zero sends no bits and still ends with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a configuration run |
| swap | input | 1 | Word-swap mode, captured at start |
| aligned | input | 1 | Image start is 32-bit aligned, captured at start |
| byte_count | input | CNT_W | Number of image bytes, captured at start |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Block takes the byte at this edge |
| pwr_en | output | 1 | Target supply enable |
| prog_n | output | 1 | Target programming request, active low |
| cclk | output | 1 | Configuration clock to the target |
| din | output | 1 | Configuration data to the target |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the block with T_PWR=6, T_SETUP=3, T_PROG=5, CCLK_HALF=2 and CNT_W=8. These short waits bring every phase boundary of the power and programming sequence into a few dozen cycles, so a per-cycle model of prog_n and cclk can follow all of it. CCLK_HALF=2 makes the high-phase length a real count rather than a single cycle, which exposes off-by-one errors in the bit timer. The 8-bit count keeps group truncation, zero-length runs and unaligned word-swap requests cheap to reach.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_SETUP,
    ST_PROG,
    ST_SHIFT,
    ST_FINISH
  } seq_state_t;

  // Slot within a 4-byte group that feeds output position pos (index XOR 3).
  function automatic logic [1:0] grp_slot(input logic [1:0] pos);
    return pos ^ 2'b11;
  endfunction

  // Number of bytes a run moves, given the captured mode and count.
  function automatic logic [31:0] bytes_to_send(input logic sw, input logic al,
                                                input logic [31:0] n);
    if (!sw) return n;
    if (!al) return 32'd0;
    return {n[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/fcfg_timer.sv
module fcfg_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (cnt != '0)         cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/fcfg_reorder.sv
module fcfg_reorder
  import fcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sw,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       draining
);
  logic [7:0] slot [4];
  logic [1:0] fill;
  logic [1:0] didx;
  logic       in_fire, out_fire;

  assign in_fire  = sw && in_valid && in_ready;
  assign out_fire = sw && out_valid && out_ready;

  always_comb begin
    if (sw) begin
      in_ready  = !draining;
      out_valid = draining;
      out_data  = slot[grp_slot(didx)];
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fill     <= '0;
      didx     <= '0;
      draining <= 1'b0;
    end else begin
      if (in_fire) begin
        fill <= fill + 2'd1;
        if (fill == 2'd3) begin
          draining <= 1'b1;
          didx     <= '0;
        end
      end
      if (out_fire) begin
        didx <= didx + 2'd1;
        if (didx == 2'd3) begin
          draining <= 1'b0;
          fill     <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (in_fire && fill == 2'(g)) slot[g] <= in_data;
    end
  end

  a_r7_hold_group: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (sw && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r7_no_take_while_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && draining) |-> !in_fire);

endmodule

// File: rtl/fcfg_shifter.sv
module fcfg_shifter #(
  parameter int HALF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  output logic       s_ready,
  output logic       cclk,
  output logic       din,
  output logic       active
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [7:0]    sr;
  logic [2:0]    bitn;
  logic          hi;
  logic [PW-1:0] pcnt;
  logic          phase_end;
  logic          rise_evt;

  assign s_ready   = !active;
  assign phase_end = (pcnt == PW'(HALF - 1));
  assign rise_evt  = active && phase_end && !hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sr     <= '0;
      bitn   <= '0;
      hi     <= 1'b0;
      pcnt   <= '0;
      din    <= 1'b0;
      cclk   <= 1'b0;
    end else if (!active) begin
      if (s_valid) begin
        active <= 1'b1;
        sr     <= s_data;
        bitn   <= 3'd7;
        hi     <= 1'b0;
        pcnt   <= '0;
        din    <= s_data[7];
        cclk   <= 1'b0;
      end
    end else if (!phase_end) begin
      pcnt <= pcnt + PW'(1);
    end else begin
      pcnt <= '0;
      if (!hi) begin
        hi   <= 1'b1;
        cclk <= 1'b1;
      end else begin
        hi   <= 1'b0;
        cclk <= 1'b0;
        if (bitn == 3'd0) active <= 1'b0;
        else begin
          bitn <= bitn - 3'd1;
          din  <= sr[bitn - 3'd1];
        end
      end
    end
  end

  a_r4_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |=> (!cclk || $stable(din)));
  a_r5_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> cclk);
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !cclk);

endmodule

// File: rtl/fcfg_seq.sv
module fcfg_seq
  import fcfg_pkg::*;
#(
  parameter int T_PWR     = 1200000,
  parameter int T_SETUP   = 24000,
  parameter int T_PROG    = 1200000,
  parameter int CCLK_HALF = 1,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             swap,
  input  logic             aligned,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             pwr_en,
  output logic             prog_n,
  output logic             cclk,
  output logic             din,
  output logic             busy,
  output logic             done
);
  localparam int TMAX = (T_PWR > T_PROG) ? ((T_PWR > T_SETUP) ? T_PWR : T_SETUP)
                                         : ((T_PROG > T_SETUP) ? T_PROG : T_SETUP);
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_t       state;
  logic             sw_q;
  logic             pwr_q;
  logic [CNT_W-1:0] in_left, out_left;
  logic [CNT_W-1:0] run_total;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          accept;
  logic          gate;
  logic          r_in_ready, r_out_valid, r_draining;
  logic [7:0]    r_out_data;
  logic          sh_ready, sh_active, sh_load;
  logic          in_fire;

  assign accept    = (state == ST_IDLE) && start;
  assign run_total = CNT_W'(bytes_to_send(swap, aligned, 32'(byte_count)));
  assign gate      = (state == ST_SHIFT) && (in_left != '0);
  assign in_ready  = gate && r_in_ready;
  assign in_fire   = in_valid && in_ready;
  assign sh_load   = r_out_valid && sh_ready && (state == ST_SHIFT) && (out_left != '0);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_PWR - 1);
    end else if (state == ST_PWR && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_SETUP - 1);
    end else if (state == ST_SETUP && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_PROG - 1);
    end
  end

  fcfg_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  fcfg_reorder u_reorder (
    .clk(clk), .rst_n(rst_n), .clr(accept), .sw(sw_q),
    .in_valid(in_valid && gate), .in_data(in_data), .in_ready(r_in_ready),
    .out_valid(r_out_valid), .out_data(r_out_data), .out_ready(sh_ready && (out_left != '0)),
    .draining(r_draining)
  );

  fcfg_shifter #(.HALF(CCLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .s_valid(sh_load), .s_data(r_out_data),
    .s_ready(sh_ready), .cclk(cclk), .din(din), .active(sh_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sw_q     <= 1'b0;
      pwr_q    <= 1'b0;
      in_left  <= '0;
      out_left <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_PWR;
          pwr_q    <= 1'b1;
          sw_q     <= swap;
          in_left  <= run_total;
          out_left <= run_total;
        end
        ST_PWR:    if (tmr_exp) state <= ST_SETUP;
        ST_SETUP:  if (tmr_exp) state <= ST_PROG;
        ST_PROG:   if (tmr_exp) state <= ST_SHIFT;
        ST_SHIFT:  if (out_left == '0 && !sh_active) state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
      if (!accept && in_fire) in_left  <= in_left - CNT_W'(1);
      if (!accept && sh_load) out_left <= out_left - CNT_W'(1);
    end
  end

  assign pwr_en = pwr_q;
  assign prog_n = (state != ST_PROG);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FINISH);

  a_r3_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !cclk);
  a_r2_power_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |=> pwr_en);
  a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r12_no_rerun: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_PWR) |=> (state != ST_PWR));
  a_r10_take_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (prog_n && pwr_en));
  a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sw_q && out_left == '0 && !sh_active) |-> !cclk);
  a_r7_no_take_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q && r_draining) |-> !in_ready);

endmodule

// File: tb/tb_fcfg_seq.sv
module tb_fcfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_PWR  = 6;
  localparam int T_SETUP = 3;
  localparam int T_PROG = 5;
  localparam int HALF   = 2;
  localparam int CNT_W  = 8;
  localparam int P0     = T_PWR + T_SETUP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, swap = 1'b0, aligned = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, pwr_en, prog_n, cclk, din, busy, done;

  fcfg_seq #(.T_PWR(T_PWR), .T_SETUP(T_SETUP), .T_PROG(T_PROG),
             .CCLK_HALF(HALF), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .swap(swap), .aligned(aligned),
    .byte_count(byte_count), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pwr_en(pwr_en), .prog_n(prog_n), .cclk(cclk),
    .din(din), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  logic acc_q = 1'b0;
  int   cyc = 0;
  bit   run = 0, started = 0;
  bit   prev_cclk = 0;
  bit   din_r = 0;
  int   hi_len = 0, lo_len = 0;
  int   done_seen = 0;
  bit   bits[$];

  always @(posedge clk) acc_q <= rst_n && start && !busy;

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_q) begin cyc = 0; run = 1; started = 1; end
      else cyc++;
      if (started) chk(pwr_en == 1'b1, "R2 power on", pwr_en, 1);
      if (run) begin
        chk(prog_n == !(cyc >= P0 && cyc < P0 + T_PROG), "R3 prog pulse", prog_n,
            !(cyc >= P0 && cyc < P0 + T_PROG));
        if (cyc < P0 + T_PROG) begin
          chk(cclk == 1'b0, "R3 cclk quiet", cclk, 0);
          chk(in_ready == 1'b0, "R10 ready before pulse end", in_ready, 0);
        end
        chk(busy == 1'b1, "R11 busy during run", busy, 1);
      end else begin
        chk(busy == 1'b0, "R11 busy after done", busy, 0);
        chk(done == 1'b0, "R11 done outside run", done, 0);
      end
      if (cclk && !prev_cclk) begin
        chk(lo_len >= HALF, "R5 low phase", lo_len, HALF);
        bits.push_back(din);
        din_r = din;
        hi_len = 1;
      end else if (cclk) begin
        hi_len++;
        chk(din == din_r, "R4 din stable", din, din_r);
      end
      if (!cclk && prev_cclk) begin
        chk(hi_len == HALF, "R5 high phase", hi_len, HALF);
        lo_len = 1;
      end else if (!cclk) lo_len++;
      prev_cclk = cclk;
      if (run && done) begin done_seen++; run = 0; end
    end
  end

  logic [7:0] src[$];

  task automatic run_case(input bit sw, input bit al, input int cnt, input bit poke,
                          input int seed, input string tag);
    int nsend;
    int ready_seen;
    int prev_done;
    logic [7:0] exp_b, got;
    nsend = !sw ? cnt : (!al ? 0 : (cnt / 4) * 4);
    src.delete();
    for (int k = 0; k < nsend; k++) src.push_back(8'((k * 37 + seed * 11) ^ 8'h5A));
    bits.delete();
    prev_done = done_seen;
    @(negedge clk);
    swap = sw; aligned = al; byte_count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nsend; k++) begin
      if (k % 3 == 1) @(negedge clk);
      if (poke && k == 2) begin start = 1'b1; @(negedge clk); start = 1'b0; end
      in_valid = 1'b1; in_data = src[k];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    in_valid = 1'b1; in_data = 8'hEE;
    ready_seen = 0;
    while (!done) begin
      if (in_ready) ready_seen++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(ready_seen == 0, {tag, " R10 no extra byte"}, ready_seen, 0);
    @(negedge clk); @(negedge clk);
    chk(done_seen == prev_done + 1, {tag, " R11 one done"}, done_seen - prev_done, 1);
    chk(busy == 1'b0, {tag, " R11 idle after"}, busy, 0);
    chk(bits.size() == 8 * nsend, {tag, " bit count"}, bits.size(), 8 * nsend);
    if (bits.size() == 8 * nsend) begin
      for (int k = 0; k < nsend; k++) begin
        exp_b = sw ? src[(k / 4) * 4 + 3 - (k % 4)] : src[k];
        got = '0;
        for (int b = 0; b < 8; b++) got = {got[6:0], bits[8 * k + b]};
        chk(got == exp_b, {tag, " byte order"}, got, exp_b);
      end
    end
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwr_en == 1'b0, "R1 pwr_en", pwr_en, 0);
    chk(prog_n == 1'b1, "R1 prog_n", prog_n, 1);
    chk(cclk == 1'b0, "R1 cclk", cclk, 0);
    chk(din == 1'b0, "R1 din", din, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    run_case(0, 1, 5, 1, 1, "R6 R12 normal with late start");
    run_case(1, 1, 8, 0, 2, "R7 swap two groups");
    run_case(1, 1, 6, 0, 3, "R8 swap truncated count");
    run_case(1, 0, 8, 0, 4, "R9 swap unaligned");
    run_case(0, 0, 0, 0, 5, "R13 empty run");
    run_case(0, 1, 3, 0, 6, "R4 R5 short normal");
    run_case(1, 1, 4, 0, 7, "R7 single group");
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule